// File: doc/BRIEF.md
# Masked Sequential Register Writer

This block applies a short burst of word writes to a window of graphics registers. A request names a byte offset inside the window and a byte length, and selects plain or masked mode. In plain mode each word taken from the data stream is written directly to the next register address. In masked mode each target register is read first. One cycle later the merged value goes back to the same address. In the merged value the mask bits that are set take the bits from the stream data, and the bits that are clear keep the current register contents.

Each request is checked before any bus access is made. A request that breaks alignment, the burst size limit or the window range ends at once with a nonzero status code. A request for zero bytes ends at once with success. The data and mask words arrive on valid/ready streams. A word is taken on any rising edge where its valid and ready are both high. The producer must keep a word and its valid stable until that edge. The block may hold ready low for as long as it needs: in masked mode it does so during every write cycle. The block raises mask ready, and in masked mode data ready, only when both streams offer a word, and it then takes the pair together.

Top module: `regwin_burst_writer`

## Requirements
- R1: A request whose offset, byte length or data-array address low bits (`data_addr_lsb`) are not all zero ends with status 1 and no bus access. In masked mode the same holds for nonzero `mask_addr_lsb`.
- R2: An aligned request with a byte length above 128 ends with status 2 and no bus access. A length of exactly 128 runs as 32 writes.
- R3: An aligned request of legal length whose offset is 0x420000 or more ends with status 3 and no bus access. Offset 0x41FFFC is accepted.
- R4: When several checks fail, alignment (1) is reported before length (2), and length before range (3).
- R5: An accepted burst makes exactly length/4 writes, at addresses 0x1EB00000 + offset, then +4 after each word.
- R6: In plain mode each accepted data word is written unchanged in the same cycle that it is taken. No bus access happens while the data stream has no word to offer.
- R7: In masked mode every register read is followed in the next cycle by a write to the same address of (current & ~mask) | (data & mask), where current is the value returned by that read.
- R8: In plain mode, `mask_addr_lsb` has no effect on the checks, and the mask stream is never taken.
- R9: A zero byte length with otherwise legal parameters ends with status 0 and no bus access.
- R10: `done` is a one-cycle pulse. For a rejected or empty request it comes in the cycle after `start`. For an accepted burst it comes in the cycle after the last write, with status 0. `busy` is high from the cycle after acceptance until done.
- R11: A `start` while `busy` is high is ignored: it neither ends the running burst nor changes its addresses.
- R12: A read and a write are never issued in the same cycle. Both stream readies are low while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, sampled when idle |
| win_offset | input | 32 | Byte offset inside the register window |
| byte_len | input | 32 | Burst length in bytes |
| use_mask | input | 1 | 1 selects masked read-modify-write mode |
| data_addr_lsb | input | 2 | Low two bits of the data array address |
| mask_addr_lsb | input | 2 | Low two bits of the mask array address |
| busy | output | 1 | Burst in progress |
| dat_valid | input | 1 | Data stream word present |
| dat_ready | output | 1 | Data stream word taken |
| dat_word | input | 32 | Data stream word |
| msk_valid | input | 1 | Mask stream word present |
| msk_ready | output | 1 | Mask stream word taken |
| msk_word | input | 32 | Mask stream word |
| reg_rd | output | 1 | Register read strobe |
| reg_wr | output | 1 | Register write strobe |
| reg_addr | output | 32 | Register bus byte address |
| reg_wdata | output | 32 | Register write data |
| reg_rdata | input | 32 | Read data, valid one cycle after `reg_rd` |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 misaligned, 2 too long, 3 out of range |

## Verification
On every cycle the assertions check that reads and writes never overlap and that each masked read is followed by a write to the same address. They also check that back-to-back writes step the address by four, that the word counter never runs empty while busy, and that an error completion never follows a bus access. Only the bench scenarios can show the values themselves: the merged data computed from preloaded register contents, the status code chosen when several checks fail, the boundary lengths and offsets, and the fact that a second start during a burst changes nothing.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_ALIGN = 2'd1,
    ST_LEN   = 2'd2,
    ST_RANGE = 2'd3
  } rw_status_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_PLAIN,
    S_MREAD,
    S_MWRITE
  } rw_state_e;
endpackage

// File: rtl/regwin_param_check.sv
module regwin_param_check
  import regwin_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int LEN_W        = 32,
  parameter int MAX_LEN      = 128,
  parameter int OFFSET_LIMIT = 32'h0042_0000
) (
  input  logic [ADDR_W-1:0] offset,
  input  logic [LEN_W-1:0]  len,
  input  logic              masked,
  input  logic [1:0]        data_lsb,
  input  logic [1:0]        mask_lsb,
  output rw_status_e        chk,
  output logic              zero_len
);
  logic misaligned, too_long, out_range;

  always_comb begin
    misaligned = (|offset[1:0]) || (|len[1:0]) || (|data_lsb) || (masked && (|mask_lsb));
    too_long   = len > LEN_W'(MAX_LEN);
    out_range  = offset >= ADDR_W'(OFFSET_LIMIT);
    zero_len   = (len == '0);
    // R4: priority alignment > length > range
    if (misaligned)     chk = ST_ALIGN;
    else if (too_long)  chk = ST_LEN;
    else if (out_range) chk = ST_RANGE;
    else                chk = ST_OK;
  end
endmodule

// File: rtl/regwin_merge.sv
module regwin_merge #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] merged
);
  localparam int LANES = DATA_W / 8;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign merged[b*8 +: 8] = (cur[b*8 +: 8] & ~mask[b*8 +: 8]) | (data[b*8 +: 8] & mask[b*8 +: 8]);
  end
endmodule

// File: rtl/regwin_seq.sv
module regwin_seq
  import regwin_pkg::*;
#(
  parameter int              ADDR_W = 32,
  parameter int              DATA_W = 32,
  parameter int              CNT_W  = 6,
  parameter logic [ADDR_W-1:0] BASE = 32'h1EB0_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] offset,
  input  logic [CNT_W-1:0]  words,
  input  logic              masked,
  input  rw_status_e        chk,
  input  logic              zero_len,
  output logic              busy,
  input  logic              d_valid,
  output logic              d_ready,
  input  logic [DATA_W-1:0] d_data,
  input  logic              m_valid,
  output logic              m_ready,
  input  logic [DATA_W-1:0] m_data,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] merged,
  output logic [DATA_W-1:0] data_q,
  output logic [DATA_W-1:0] mask_q,
  output logic              done,
  output rw_status_e        status
);
  rw_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              pair_ok, step, last;

  assign pair_ok   = (state_q == S_MREAD) && d_valid && m_valid;
  assign d_ready   = (state_q == S_PLAIN) || pair_ok;
  assign m_ready   = pair_ok;
  assign bus_rd    = pair_ok;
  assign bus_wr    = ((state_q == S_PLAIN) && d_valid) || (state_q == S_MWRITE);
  assign bus_addr  = addr_q;
  assign bus_wdata = (state_q == S_MWRITE) ? merged : d_data;
  assign busy      = (state_q != S_IDLE);
  assign step      = bus_wr;
  assign last      = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
      mask_q  <= '0;
      done    <= 1'b0;
      status  <= ST_OK;
    end else begin
      done <= 1'b0;
      case (state_q)
        S_IDLE: if (start) begin
          if (chk != ST_OK) begin
            done   <= 1'b1;
            status <= chk;
          end else if (zero_len) begin
            done   <= 1'b1;
            status <= ST_OK;
          end else begin
            addr_q  <= BASE + offset;
            cnt_q   <= words;
            state_q <= masked ? S_MREAD : S_PLAIN;
          end
        end
        S_MREAD: if (pair_ok) begin
          data_q  <= d_data;
          mask_q  <= m_data;
          state_q <= S_MWRITE;
        end
        default: ;
      endcase
      if (step) begin
        addr_q <= addr_q + ADDR_W'(4);
        cnt_q  <= cnt_q - CNT_W'(1);
        if (last) begin
          done    <= 1'b1;
          status  <= ST_OK;
          state_q <= S_IDLE;
        end else if (state_q == S_MWRITE) begin
          state_q <= S_MREAD;
        end
      end
    end
  end

  a_r12_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  a_r7_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> (bus_wr && bus_addr == $past(bus_addr)));

  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> (!bus_wr || bus_addr == $past(bus_addr) + ADDR_W'(4)));

  a_r5_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q != '0));

  a_r1_error_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status != ST_OK) |-> $past(!bus_rd && !bus_wr));

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/regwin_burst_writer.sv
module regwin_burst_writer
  import regwin_pkg::*;
#(
  parameter int              ADDR_W       = 32,
  parameter int              DATA_W       = 32,
  parameter int              LEN_W        = 32,
  parameter int              MAX_LEN      = 128,
  parameter int              OFFSET_LIMIT = 32'h0042_0000,
  parameter logic [ADDR_W-1:0] BASE       = 32'h1EB0_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] win_offset,
  input  logic [LEN_W-1:0]  byte_len,
  input  logic              use_mask,
  input  logic [1:0]        data_addr_lsb,
  input  logic [1:0]        mask_addr_lsb,
  output logic              busy,
  input  logic              dat_valid,
  output logic              dat_ready,
  input  logic [DATA_W-1:0] dat_word,
  input  logic              msk_valid,
  output logic              msk_ready,
  input  logic [DATA_W-1:0] msk_word,
  output logic              reg_rd,
  output logic              reg_wr,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              done,
  output logic [1:0]        status
);
  localparam int MAX_WORDS = MAX_LEN / 4;
  localparam int CNT_W     = $clog2(MAX_WORDS + 1);

  rw_status_e        chk, st;
  logic              zero_len;
  logic [CNT_W-1:0]  words;
  logic [DATA_W-1:0] merged, data_q, mask_q;

  assign words  = byte_len[CNT_W+1:2];
  assign status = st;

  regwin_param_check #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN), .OFFSET_LIMIT(OFFSET_LIMIT)
  ) u_check (
    .offset(win_offset), .len(byte_len), .masked(use_mask),
    .data_lsb(data_addr_lsb), .mask_lsb(mask_addr_lsb),
    .chk(chk), .zero_len(zero_len)
  );

  regwin_merge #(.DATA_W(DATA_W)) u_merge (
    .cur(reg_rdata), .data(data_q), .mask(mask_q), .merged(merged)
  );

  regwin_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .BASE(BASE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .offset(win_offset), .words(words),
    .masked(use_mask), .chk(chk), .zero_len(zero_len), .busy(busy),
    .d_valid(dat_valid), .d_ready(dat_ready), .d_data(dat_word),
    .m_valid(msk_valid), .m_ready(msk_ready), .m_data(msk_word),
    .bus_rd(reg_rd), .bus_wr(reg_wr), .bus_addr(reg_addr), .bus_wdata(reg_wdata),
    .merged(merged), .data_q(data_q), .mask_q(mask_q), .done(done), .status(st)
  );
endmodule

// File: tb/regwin_burst_writer_bench.sv
module regwin_burst_writer_bench;
  localparam logic [31:0] BASE = 32'h1EB0_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] win_offset = '0;
  logic [31:0] byte_len = '0;
  logic        use_mask = 1'b0;
  logic [1:0]  data_addr_lsb = '0;
  logic [1:0]  mask_addr_lsb = '0;
  logic        busy, dat_ready, msk_ready, reg_rd, reg_wr, done;
  logic        dat_valid = 1'b0;
  logic        msk_valid = 1'b0;
  logic [31:0] dat_word = '0;
  logic [31:0] msk_word = '0;
  logic [31:0] reg_addr, reg_wdata;
  logic [31:0] reg_rdata = '0;
  logic [1:0]  status;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int nwr = 0;
  int nrd = 0;
  logic [31:0] model [256];
  logic [31:0] wr_addr [64];
  logic [31:0] wr_data [64];
  int          wr_cyc [64];
  int          rd_cyc [64];
  logic [31:0] sdat [64];
  logic [31:0] smsk [64];

  always #10 clk = ~clk;

  regwin_burst_writer u_regwin_burst_writer (
    .clk(clk), .rst_n(rst_n), .start(start), .win_offset(win_offset), .byte_len(byte_len),
    .use_mask(use_mask), .data_addr_lsb(data_addr_lsb), .mask_addr_lsb(mask_addr_lsb),
    .busy(busy), .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_word(dat_word),
    .msk_valid(msk_valid), .msk_ready(msk_ready), .msk_word(msk_word),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .done(done), .status(status)
  );

  // register file model with one-cycle read latency, plus access log
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (reg_wr) begin
      model[reg_addr[9:2]] <= reg_wdata;
      if (nwr < 64) begin
        wr_addr[nwr] <= reg_addr;
        wr_data[nwr] <= reg_wdata;
        wr_cyc[nwr]  <= cyc;
      end
      nwr <= nwr + 1;
    end
    if (reg_rd) begin
      reg_rdata <= model[reg_addr[9:2]];
      if (nrd < 64) rd_cyc[nrd] <= cyc;
      nrd <= nrd + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic [31:0] off, input logic [31:0] len, input bit m,
                        input logic [1:0] dl, input logic [1:0] ml);
    @(negedge clk);
    win_offset = off; byte_len = len; use_mask = m;
    data_addr_lsb = dl; mask_addr_lsb = ml; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output logic [1:0] st, output bit seen);
    seen = 0; st = '0;
    for (int i = 0; i < 400; i++) begin
      if (done) begin seen = 1; st = status; break; end
      @(negedge clk);
    end
  endtask

  task automatic feed(input int n, input bit m, input int gap_at, input int gap_len);
    for (int i = 0; i < n; i++) begin
      if (i == gap_at) repeat (gap_len) @(negedge clk);
      dat_valid = 1'b1; dat_word = sdat[i];
      msk_valid = m;    msk_word = smsk[i];
      for (int k = 0; k < 50; k++) begin
        #1;
        if (dat_ready) begin @(negedge clk); break; end
        @(negedge clk);
      end
      dat_valid = 1'b0; msk_valid = 1'b0;
    end
  endtask

  task automatic run(input logic [31:0] off, input logic [31:0] len, input bit m,
                     input logic [1:0] dl, input logic [1:0] ml, input int n,
                     input int gap_at, input int gap_len,
                     output logic [1:0] st, output bit seen);
    nwr = 0; nrd = 0;
    fork
      begin launch(off, len, m, dl, ml); wait_done(st, seen); end
      begin @(negedge clk); @(negedge clk); feed(n, m, gap_at, gap_len); end
    join
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!done && !busy, "R10", "idle after reset", {30'd0, done, busy}, 32'd0);
    chk(!reg_rd && !reg_wr && !dat_ready && !msk_ready, "R12", "quiet after reset",
        {28'd0, reg_rd, reg_wr, dat_ready, msk_ready}, 32'd0);
  endtask

  task automatic t_plain();
    logic [1:0] st; bit seen; bit ok;
    for (int i = 0; i < 4; i++) sdat[i] = 32'hC0DE_0000 + 32'(i * 17);
    run(32'h100, 32'd16, 0, 2'd0, 2'd0, 4, -1, 0, st, seen);
    chk(seen && st == 2'd0, "R10", "plain status", {30'd0, st}, 32'd0);
    chk(nwr == 4, "R5", "plain write count", 32'(nwr), 32'd4);
    ok = 1;
    for (int i = 0; i < 4; i++)
      if (wr_addr[i] != BASE + 32'h100 + 32'(4*i) || wr_data[i] != sdat[i]) ok = 0;
    chk(ok, "R6", "plain addresses and data", wr_data[3], sdat[3]);
    chk(wr_cyc[3] - wr_cyc[0] == 3, "R6", "one write per cycle", 32'(wr_cyc[3] - wr_cyc[0]), 32'd3);
    chk(nrd == 0, "R6", "no reads in plain mode", 32'(nrd), 32'd0);
  endtask

  task automatic t_stall();
    logic [1:0] st; bit seen;
    for (int i = 0; i < 3; i++) sdat[i] = 32'h0BAD_F00D ^ 32'(i);
    run(32'h180, 32'd12, 0, 2'd0, 2'd0, 3, 1, 2, st, seen);
    chk(nwr == 3 && st == 2'd0, "R6", "stalled burst writes", 32'(nwr), 32'd3);
    chk(wr_cyc[1] - wr_cyc[0] == 3, "R6", "no write during stall", 32'(wr_cyc[1] - wr_cyc[0]), 32'd3);
    chk(wr_data[2] == sdat[2] && wr_addr[2] == BASE + 32'h188, "R5", "address after stall",
        wr_addr[2], BASE + 32'h188);
  endtask

  task automatic t_masked();
    logic [1:0] st; bit seen; bit ok; bit tok;
    logic [31:0] old [3];
    logic [31:0] exp;
    old[0] = 32'hA5A5_A5A5; old[1] = 32'h1234_5678; old[2] = 32'hFFFF_0000;
    for (int i = 0; i < 3; i++) sdat[i] = old[i];
    run(32'h40, 32'd12, 0, 2'd0, 2'd0, 3, -1, 0, st, seen);
    sdat[0] = 32'h5A5A_5A5A; smsk[0] = 32'hFF00_FF00;
    sdat[1] = 32'hDEAD_BEEF; smsk[1] = 32'h0000_0000;
    sdat[2] = 32'h0F0F_0F0F; smsk[2] = 32'hFFFF_FFFF;
    run(32'h40, 32'd12, 1, 2'd0, 2'd0, 3, -1, 0, st, seen);
    chk(seen && st == 2'd0, "R10", "masked status", {30'd0, st}, 32'd0);
    chk(nrd == 3 && nwr == 3, "R7", "masked read and write counts", 32'(nrd * 16 + nwr), 32'h33);
    ok = 1; tok = 1;
    for (int i = 0; i < 3; i++) begin
      exp = (old[i] & ~smsk[i]) | (sdat[i] & smsk[i]);
      if (wr_data[i] != exp || wr_addr[i] != BASE + 32'h40 + 32'(4*i)) begin
        ok = 0;
        $display("  masked word %0d: got %h want %h", i, wr_data[i], exp);
      end
      if (wr_cyc[i] != rd_cyc[i] + 1) tok = 0;
    end
    chk(ok, "R7", "masked merge values", wr_data[0], (old[0] & ~smsk[0]) | (sdat[0] & smsk[0]));
    chk(tok, "R7", "write one cycle after read", 32'(wr_cyc[0] - rd_cyc[0]), 32'd1);
  endtask

  task automatic expect_err(input logic [31:0] off, input logic [31:0] len, input bit m,
                            input logic [1:0] dl, input logic [1:0] ml,
                            input logic [1:0] code, input string req);
    logic [1:0] st; bit seen;
    nwr = 0; nrd = 0;
    launch(off, len, m, dl, ml);
    seen = done; st = status;
    chk(seen && st == code, req, "status right after start", {30'd0, st}, {30'd0, code});
    @(negedge clk);
    chk(!done && nwr == 0 && nrd == 0, req, "one-cycle done, no bus access",
        32'(nwr + nrd) | {31'd0, done}, 32'd0);
  endtask

  task automatic t_errors();
    expect_err(32'h102, 32'd8,   0, 2'd0, 2'd0, 2'd1, "R1");
    expect_err(32'h100, 32'd6,   0, 2'd0, 2'd0, 2'd1, "R1");
    expect_err(32'h100, 32'd8,   0, 2'd2, 2'd0, 2'd1, "R1");
    expect_err(32'h100, 32'd8,   1, 2'd0, 2'd1, 2'd1, "R1");
    expect_err(32'h100, 32'h84,  0, 2'd0, 2'd0, 2'd2, "R2");
    expect_err(32'h420000, 32'd4, 0, 2'd0, 2'd0, 2'd3, "R3");
    expect_err(32'h420001, 32'h200, 0, 2'd0, 2'd0, 2'd1, "R4");
    expect_err(32'h420000, 32'h200, 0, 2'd0, 2'd0, 2'd2, "R4");
  endtask

  task automatic t_bounds();
    logic [1:0] st; bit seen;
    for (int i = 0; i < 32; i++) sdat[i] = 32'h7700_0000 + 32'(i);
    run(32'h0, 32'h80, 0, 2'd0, 2'd0, 32, -1, 0, st, seen);
    chk(st == 2'd0 && nwr == 32, "R2", "128-byte burst", 32'(nwr), 32'd32);
    chk(wr_addr[31] == BASE + 32'h7C && wr_data[31] == sdat[31], "R5", "last address of max burst",
        wr_addr[31], BASE + 32'h7C);
    sdat[0] = 32'h1357_9BDF;
    run(32'h41FFFC, 32'd4, 0, 2'd0, 2'd0, 1, -1, 0, st, seen);
    chk(st == 2'd0 && nwr == 1 && wr_addr[0] == BASE + 32'h41FFFC, "R3", "top word of window",
        wr_addr[0], BASE + 32'h41FFFC);
  endtask

  task automatic t_plain_mask_ignored();
    logic [1:0] st; bit seen; bit mtaken;
    sdat[0] = 32'h2468_ACE0; sdat[1] = 32'h1111_2222;
    nwr = 0; nrd = 0; mtaken = 0;
    fork
      begin launch(32'h200, 32'd8, 0, 2'd0, 2'd3); wait_done(st, seen); end
      begin
        @(negedge clk); @(negedge clk);
        msk_valid = 1'b1;
        for (int i = 0; i < 2; i++) begin
          dat_valid = 1'b1; dat_word = sdat[i];
          #1;
          if (msk_ready) mtaken = 1;
          @(negedge clk);
        end
        dat_valid = 1'b0; msk_valid = 1'b0;
      end
    join
    @(negedge clk);
    chk(seen && st == 2'd0 && nwr == 2, "R8", "mask lsb ignored in plain mode", {30'd0, st}, 32'd0);
    chk(!mtaken, "R8", "mask stream untouched", {31'd0, mtaken}, 32'd0);
  endtask

  task automatic t_zero();
    logic [1:0] st; bit seen;
    nwr = 0; nrd = 0;
    launch(32'h300, 32'd0, 1, 2'd0, 2'd0);
    seen = done; st = status;
    chk(seen && st == 2'd0, "R9", "zero length completes", {30'd0, st}, 32'd0);
    @(negedge clk);
    chk(nwr == 0 && nrd == 0 && !busy, "R9", "zero length no access", 32'(nwr + nrd), 32'd0);
  endtask

  task automatic t_busy_start();
    logic [1:0] st; bit seen; bit early;
    sdat[0] = 32'hAAAA_0001; sdat[1] = 32'hAAAA_0002;
    nwr = 0; nrd = 0; early = 0;
    launch(32'h280, 32'd8, 0, 2'd0, 2'd0);
    chk(busy, "R10", "busy after accept", {31'd0, busy}, 32'd1);
    win_offset = 32'h3; byte_len = 32'h4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (done) early = 1;
      @(negedge clk);
    end
    chk(!early, "R11", "start while busy gives no done", {31'd0, early}, 32'd0);
    fork
      wait_done(st, seen);
      feed(2, 0, -1, 0);
    join
    @(negedge clk);
    chk(seen && st == 2'd0 && nwr == 2 && wr_addr[0] == BASE + 32'h280 && wr_addr[1] == BASE + 32'h284,
        "R11", "burst unchanged by second start", wr_addr[0], BASE + 32'h280);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin sdat[i] = '0; smsk[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_stall();
    t_masked();
    t_errors();
    t_bounds();
    t_plain_mask_ignored();
    t_zero();
    t_busy_start();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule